// File: doc/BRIEF.md
# Dual-Strobe Decade Up/Down Counter

This block holds one decimal digit (codes 0 to 9) and steps it up or down. It has no direction input. Instead it has two strobes, one per direction, and the rising strobe sets the direction. Both strobes idle high. The strobes are treated as asynchronous signals: each one passes through a synchronizer in the system clock domain, and its rising edges are detected there. A step is taken only when the other strobe has stayed high.

The digit has two overriding controls. A master clear forces the digit to zero. An active-low preset makes the digit follow a 4-bit data input. Both act on the output at once, without waiting for a clock edge, and the register keeps the forced value after the control is released. Two active-low terminal outputs mark overflow and underflow. Each one is gated by the low phase of its own strobe, so a chain of digits is built by wiring the carry output of one stage to the up strobe of the next, and the borrow output to the down strobe. A preset into codes 10 to 15 is allowed, and the counter has a defined path from each of these codes back into the decimal range.

Top module: `bcd_updown_counter`

## Requirements
- R1: While `clr` is high, `count` reads 0, and after `clr` falls the digit stays 0 until a step or a preset.
- R2: While `load_n` is low and `clr` is low, `count` equals `din`, and after `load_n` rises the digit keeps the last `din` value.
- R3: When `clr` and `load_n` are active together, the clear wins and `count` reads 0.
- R4: A rising edge on `up_stb` while `dn_stb` stays high adds one to the digit. `count` changes on the third rising `clk` edge after the strobe rises.
- R5: A rising edge on `dn_stb` while `up_stb` stays high subtracts one from the digit, with the same three-edge latency as R4.
- R6: Stepping up from 9 gives 0 and stepping down from 0 gives 9. Starting from a code of 9 or less, a step never leaves the range 0 to 9.
- R7: Stepping up from a non-decimal code follows 10→11, 11→6, 12→13, 13→4, 14→15, 15→2.
- R8: Stepping down from a non-decimal code subtracts one (15→14→…→10→9).
- R9: `carry_n` is low exactly when count bit 0 and count bit 3 are both 1 and `up_stb` is low (codes 9, 11, 13, 15).
- R10: `borrow_n` is low exactly when `count` is 0 and `dn_stb` is low.
- R11: If both strobes rise in the same sampled clock cycle, the digit does not change.
- R12: A strobe edge that is detected while `clr` or `load_n` is active, or in the first clock cycle after they are released, is ignored.
- R13: A rising edge on one strobe while the other strobe is low does not change the digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Asynchronous active-low system reset. Sets the digit to 0 and the strobe samples to idle high |
| clr | input | 1 | Master clear, active high |
| load_n | input | 1 | Preset, active low. `count` follows `din` while low |
| din | input | 4 | Preset value |
| up_stb | input | 1 | Up strobe. A rising edge counts up |
| dn_stb | input | 1 | Down strobe. A rising edge counts down |
| count | output | 4 | Current digit |
| carry_n | output | 1 | Active-low overflow terminal output |
| borrow_n | output | 1 | Active-low underflow terminal output |

## Verification
`clr` and `load_n` act on `count` within the same cycle, and the terminal outputs follow the strobe level within the same cycle. A strobe edge shows on `count` at the third rising clock edge after the strobe moves. The bench drives every input on the falling edge and compares all three outputs one nanosecond later in every cycle. Its reference keeps a short history of strobe samples taken at each rising edge, so the model takes a step in the same cycle in which the design should. Every preset value from 0 to 15 is stepped seven times in each direction, and separate sequences cover simultaneous edges, a strobe held low, edges that arrive during or just after a preset, and clear taking priority over preset.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned TOP_CODE = 9;

  typedef logic [DIGIT_W-1:0] digit_t;

  // Step up: decimal wrap at TOP_CODE, odd non-decimal codes fold back
  // into the decimal range (11->6, 13->4, 15->2), even ones go to the next odd.
  function automatic digit_t digit_inc(digit_t c);
    digit_t r;
    if (c == digit_t'(TOP_CODE))      r = '0;
    else if (c < digit_t'(TOP_CODE))  r = c + digit_t'(1);
    else if (!c[0])                   r = c + digit_t'(1);
    else                              r = digit_t'(5'd17 - 5'(c));
    return r;
  endfunction

  // Step down: zero wraps to TOP_CODE, everything else subtracts one.
  function automatic digit_t digit_dec(digit_t c);
    digit_t r;
    if (c == '0) r = digit_t'(TOP_CODE);
    else         r = c - digit_t'(1);
    return r;
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic rise_o,
  output logic held_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // Synchronizer chain, reset to the idle (high) level of the strobe.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b1;
        else        sync_q[0] <= strobe_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= 1'b1;
        else        sync_q[s] <= sync_q[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[LAST];
  end

  assign rise_o = sync_q[LAST] & ~prev_q;
  assign held_o = sync_q[LAST] &  prev_q;
endmodule

// File: rtl/count_core.sv
module count_core
  import bcd_ctr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   load_n,
  input  digit_t din,
  input  logic   up_go,
  input  logic   dn_go,
  output digit_t cnt_o
);
  digit_t cnt_q, cnt_d;
  logic   blk_q, blk_d;
  logic   step_en;

  // Steps are allowed only with both overrides idle, and not in the
  // first cycle after one of them was active.
  assign step_en = ~clr & load_n & ~blk_q;
  assign blk_d   = clr | ~load_n;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                 cnt_d = '0;
    else if (!load_n)        cnt_d = din;
    else if (step_en && up_go) cnt_d = digit_inc(cnt_q);
    else if (step_en && dn_go) cnt_d = digit_dec(cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      blk_q <= blk_d;
    end
  end

  assign cnt_o = cnt_q;

  assert_clear_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  assert_preset_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load_n) |=> (cnt_q == $past(din)));

  assert_decimal_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= digit_t'(TOP_CODE) && !clr && load_n) |=> (cnt_q <= digit_t'(TOP_CODE)));

  assert_release_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q && !clr && load_n) |=> $stable(cnt_q));
endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
  import bcd_ctr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       load_n,
  input  logic [3:0] din,
  input  logic       up_stb,
  input  logic       dn_stb,
  output logic [3:0] count,
  output logic       carry_n,
  output logic       borrow_n
);
  localparam int unsigned N_DIR = 2;
  localparam int unsigned UP    = 0;
  localparam int unsigned DN    = 1;

  logic [N_DIR-1:0] stb_raw, stb_rise, stb_held;
  logic             up_go, dn_go;
  digit_t           cnt_reg, cnt_vis;

  assign stb_raw[UP] = up_stb;
  assign stb_raw[DN] = dn_stb;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (stb_raw[d]),
      .rise_o   (stb_rise[d]),
      .held_o   (stb_held[d])
    );
  end

  // A direction counts only while the opposite strobe stayed high.
  assign up_go = stb_rise[UP] & stb_held[DN];
  assign dn_go = stb_rise[DN] & stb_held[UP];

  count_core u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .load_n (load_n),
    .din    (din),
    .up_go  (up_go),
    .dn_go  (dn_go),
    .cnt_o  (cnt_reg)
  );

  // Overrides reach the output without waiting for a clock edge.
  always_comb begin
    if (clr)          cnt_vis = '0;
    else if (!load_n) cnt_vis = din;
    else              cnt_vis = cnt_reg;
  end

  assign count    = cnt_vis;
  assign carry_n  = ~(cnt_vis[0] & cnt_vis[3] & ~up_stb);
  assign borrow_n = ~((cnt_vis == '0) & ~dn_stb);

  assert_dual_rise_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise[UP] && stb_rise[DN] && !clr && load_n) |=> $stable(cnt_reg));

  assert_opposite_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_held[UP] && !stb_held[DN] && !clr && load_n) |=> $stable(cnt_reg));

  assert_exclusive_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_go && dn_go));
endmodule

// File: tb/tb_bcd_updown_counter.sv
`timescale 1ns/1ps
module tb_bcd_updown_counter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       clr, load_n, up_stb, dn_stb;
  logic [3:0] din;
  logic [3:0] count;
  logic       carry_n, borrow_n;

  int    n_chk = 0;
  int    n_err = 0;
  string cur_tag = "R1";
  int    m_cnt;
  bit    u1, u2, u3, d1, d2, d3, bprev;

  always #2 clk = ~clk;

  bcd_updown_counter dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .din(din),
    .up_stb(up_stb), .dn_stb(dn_stb), .count(count),
    .carry_n(carry_n), .borrow_n(borrow_n)
  );

  function automatic int ref_up(int c);
    if (c == 9)  return 0;
    if (c < 9)   return c + 1;
    case (c)
      10: return 11;  11: return 6;
      12: return 13;  13: return 4;
      14: return 15;  default: return 2;
    endcase
  endfunction

  function automatic int ref_dn(int c);
    return (c == 0) ? 9 : c - 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // Reference: strobe samples taken at each rising edge; an edge seen two
  // samples back is acted upon at the current edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; u1 = 1; u2 = 1; u3 = 1; d1 = 1; d2 = 1; d3 = 1; bprev = 0;
    end else begin
      bit go_up, go_dn, blk;
      blk   = clr | ~load_n;
      go_up = u2 & ~u3 & d2 & d3;
      go_dn = d2 & ~d3 & u2 & u3;
      if (clr)            m_cnt = 0;
      else if (!load_n)   m_cnt = din;
      else if (!bprev) begin
        if (go_up)        m_cnt = ref_up(m_cnt);
        else if (go_dn)   m_cnt = ref_dn(m_cnt);
      end
      u3 = u2; u2 = u1; u1 = up_stb;
      d3 = d2; d2 = d1; d1 = dn_stb;
      bprev = blk;
    end
  end

  // Every-cycle comparison, one nanosecond after inputs move.
  always @(negedge clk) begin
    int vis;
    #1;
    vis = clr ? 0 : (!load_n ? int'(din) : m_cnt);
    chk(cur_tag, count, vis);
    chk("R9",  carry_n,  (vis % 2 == 1 && vis >= 8 && !up_stb) ? 0 : 1);
    chk("R10", borrow_n, (vis == 0 && !dn_stb) ? 0 : 1);
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic preset(input int v);
    @(negedge clk); din = 4'(v); load_n = 0;
    @(negedge clk); load_n = 1;
    cycles(3);
  endtask

  task automatic pulse_up();
    @(negedge clk); up_stb = 0;
    cycles(3); up_stb = 1;
    cycles(4);
  endtask

  task automatic pulse_dn();
    @(negedge clk); dn_stb = 0;
    cycles(3); dn_stb = 1;
    cycles(4);
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; clr = 0; load_n = 1; din = 0; up_stb = 1; dn_stb = 1;
    cycles(3);
    chk("R1", count, 0);
    chk("R9", carry_n, 1);
    rst_n = 1;
    cycles(2);

    // Sweep every preset value in both directions.
    for (int p = 0; p < 16; p++) begin
      cur_tag = (p > 9) ? "R7" : "R4";
      preset(p);
      chk("R2", count, p);
      for (int k = 0; k < 7; k++) pulse_up();
      cur_tag = (p > 9) ? "R8" : "R5";
      preset(p);
      for (int k = 0; k < 7; k++) pulse_dn();
    end

    cur_tag = "R6";
    preset(9); pulse_up();  chk("R6", count, 0);
    preset(0); pulse_dn();  chk("R6", count, 9);
    cur_tag = "R7";
    preset(11); pulse_up(); chk("R7", count, 6);
    preset(15); pulse_up(); chk("R7", count, 2);
    cur_tag = "R8";
    preset(15); pulse_dn(); chk("R8", count, 14);

    cur_tag = "R9";
    preset(13);
    @(negedge clk); up_stb = 0; #1 chk("R9", carry_n, 0);
    @(negedge clk); up_stb = 1; #1 chk("R9", carry_n, 1);
    cycles(4);
    cur_tag = "R10";
    preset(0);
    @(negedge clk); dn_stb = 0; #1 chk("R10", borrow_n, 0);
    @(negedge clk); dn_stb = 1; cycles(4);
    chk("R10", count, 9);

    cur_tag = "R11";
    preset(5);
    @(negedge clk); up_stb = 0; dn_stb = 0;
    cycles(3); up_stb = 1; dn_stb = 1;
    cycles(5);
    chk("R11", count, 5);

    cur_tag = "R13";
    preset(5);
    @(negedge clk); dn_stb = 0;
    cycles(2); pulse_up();
    chk("R13", count, 5);
    @(negedge clk); dn_stb = 1; cycles(5);
    chk("R5", count, 4);

    cur_tag = "R12";
    preset(3);
    @(negedge clk); up_stb = 0; cycles(3);
    din = 4'd7; load_n = 0; up_stb = 1;
    cycles(2); load_n = 1;
    cycles(5);
    chk("R12", count, 7);

    cur_tag = "R3";
    @(negedge clk); clr = 1; din = 4'd8; load_n = 0;
    #1 chk("R3", count, 0);
    cycles(2); clr = 0; load_n = 1;
    cur_tag = "R1";
    cycles(3);
    chk("R1", count, 0);
    pulse_up();
    chk("R4", count, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule